// File: doc/BRIEF.md
# Transmit Word Elastic Input Stage

This block is the per-channel input stage in front of a serial transmitter. Each channel takes one 10-bit word on every rising edge of its own write clock and hands it out on a shared read clock. The read clock comes from the clean reference that also drives the transmit synthesizer. The write clocks run at the same frequency as the read clock, but each may have any fixed phase to it. A small Gray-pointer FIFO in each channel crosses the words between the two clock domains.

The pointers are aligned only when reset is released. The read side waits until the write pointer, as seen through its synchronizer, is two entries ahead, and then reads one word per cycle. After that the stage tolerates a bounded phase drift. If the drift grows until the pointers meet or the buffer fills, a sticky flag per channel reports it. A per-channel mode input can bypass the FIFO. In that mode the input word is sampled straight on the read clock and the write clock is ignored. Both channels read out on the common word-rate clock.

Top module: `tx_word_elastic`

## Requirements
- R1: In FIFO mode (refMode bit = 0) a channel stores the word present at the third rising edge of its write clock after rstN goes high, and one word at every later rising edge. The output presents these words in order, without loss or repetition, and outValid is high in each read cycle that carries a word.
- R2: In FIFO mode the first word appears at the output (outValid high) no later than the twelfth rising edge of rdClk after rstN goes high. This holds for any fixed write-clock phase.
- R3: Once a FIFO-mode channel has started, with its write clock running and locked to rdClk, outValid stays high on every read cycle.
- R4: While rstN is low, and after reset until a channel's first word, that channel's dataOut slice is zero and its outValid is low.
- R5: driftErr for a channel is set when the channel underflows (its write clock stops while reads continue) or overflows (rdClk stops while writes continue). Once set it stays set until rstN is driven low, which clears it.
- R6: In reference mode (refMode bit = 1), from the third rdClk rising edge after rstN goes high, dataOut carries the dataIn slice sampled at the latest rdClk edge and outValid is high. That channel's write clock has no effect, and its driftErr stays low.
- R7: The channels are independent. A fault on one channel leaves the other channel's driftErr low and its data stream intact. Channel c uses bits [10c+9:10c] of dataIn and dataOut and bit c of the single-bit vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdClk | input | 1 | Shared word-rate read clock derived from the reference |
| rstN | input | 1 | Asynchronous active-low reset; pointer alignment happens at its release |
| wrClk | input | 2 | Per-channel write clock, frequency-locked to rdClk |
| refMode | input | 2 | Per-channel bypass: 1 samples dataIn on rdClk, 0 uses the FIFO |
| dataIn | input | 20 | Input words, 10 bits per channel |
| dataOut | output | 20 | Output words in the rdClk domain, 10 bits per channel |
| outValid | output | 2 | High when the corresponding dataOut slice holds a fresh word |
| driftErr | output | 2 | Sticky per-channel underflow/overflow flag, cleared by reset |

## Verification
The hardest conditions to reach from the ports are the drift faults, because locked clocks never produce them. The bench creates underflow by gating one channel's write clock for four periods while reads continue. It creates overflow by holding rdClk low for six periods while both write clocks keep running. A behavioural queue per channel, filled at every write edge after the documented start edge, is compared against each valid output. The other channel's flag and data are checked through each fault, and a second reset pass shifts a write-clock phase and puts one channel in reference mode with its write clock stopped.

// File: rtl/tx_word_elastic_pkg.sv
package tx_word_elastic_pkg;

  parameter int FIFO_DEPTH = 8;
  localparam int ADDR_W = $clog2(FIFO_DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } fifoStrobes_t;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/tx_elastic_ctrl.sv
module tx_elastic_ctrl
  import tx_word_elastic_pkg::*;
#(
  parameter int START_GAP = 2
) (
  input  logic         wrClk,
  input  logic         rdClk,
  input  logic         rstN,
  input  logic         rdRst,
  input  logic         refMode,
  output fifoStrobes_t strb,
  output logic         driftErr
);

  localparam logic [PTR_W-1:0] GAP_LIM  = PTR_W'(START_GAP);
  localparam logic [PTR_W-1:0] FULL_LIM = PTR_W'(FIFO_DEPTH - 1);

  // ---------------- write-clock domain ----------------
  logic [1:0]       wrRstPipe;
  logic             wrRun;
  logic [PTR_W-1:0] wrBin;
  logic [PTR_W-1:0] wrGray;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrRstPipe <= '0;
    else       wrRstPipe <= {wrRstPipe[0], 1'b1};
  end

  assign wrRun = wrRstPipe[1] && !refMode;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrRun) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= bin2gray(wrBin + 1'b1);
    end
  end

  // ---------------- read-clock domain ----------------
  logic [PTR_W-1:0] graySync1;
  logic [PTR_W-1:0] graySync2;
  logic [PTR_W-1:0] rdBin;
  logic [PTR_W-1:0] fillSeen;
  logic             running;
  logic             rdGo;

  assign fillSeen = gray2bin(graySync2) - rdBin;
  assign rdGo     = running && !refMode && (fillSeen != '0);

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      graySync1 <= '0;
      graySync2 <= '0;
      rdBin     <= '0;
      running   <= 1'b0;
      driftErr  <= 1'b0;
    end else begin
      graySync1 <= wrGray;
      graySync2 <= graySync1;
      if (!refMode && fillSeen >= GAP_LIM) running <= 1'b1;
      if (rdGo) rdBin <= rdBin + 1'b1;
      if (running && ((fillSeen == '0) || (fillSeen >= FULL_LIM))) driftErr <= 1'b1;
    end
  end

  always_comb begin
    strb.wrEn   = wrRun;
    strb.wrAddr = wrBin[ADDR_W-1:0];
    strb.rdEn   = rdGo;
    strb.rdAddr = rdBin[ADDR_W-1:0];
  end

  // R5: the drift flag never drops without reset
  a_r5_err_sticky: assert property (@(posedge rdClk) disable iff (rdRst)
    driftErr |=> driftErr);

  // R6: bypassed channel never reports drift
  a_r6_ref_no_err: assert property (@(posedge rdClk) disable iff (rdRst)
    refMode |-> !driftErr);

  // R1: write address advances by exactly one per active write edge
  a_r1_wr_step: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrRun && $past(wrRun)) |-> (wrBin == PTR_W'($past(wrBin) + 1'b1)));

endmodule

// File: rtl/tx_elastic_datapath.sv
module tx_elastic_datapath
  import tx_word_elastic_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              refMode,
  input  logic [WORD_W-1:0] dataIn,
  input  fifoStrobes_t      strb,
  output logic [WORD_W-1:0] dataOut,
  output logic              outValid
);

  logic [WORD_W-1:0] store [FIFO_DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) store[strb.wrAddr] <= dataIn;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      dataOut  <= '0;
      outValid <= 1'b0;
    end else if (refMode) begin
      dataOut  <= dataIn;
      outValid <= 1'b1;
    end else if (strb.rdEn) begin
      dataOut  <= store[strb.rdAddr];
      outValid <= 1'b1;
    end else begin
      outValid <= 1'b0;
    end
  end

  // Tracks whether any word has been loaded since reset
  logic anyRead;
  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)                      anyRead <= 1'b0;
    else if (strb.rdEn || refMode)  anyRead <= 1'b1;
  end

  // R4: output stays zero until a word has been read
  a_r4_zero_until_read: assert property (@(posedge rdClk) disable iff (rdRst)
    !anyRead |-> (dataOut == '0 && !outValid));

endmodule

// File: rtl/tx_word_elastic.sv
module tx_word_elastic
  import tx_word_elastic_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int WORD_W    = 10,
  parameter int START_GAP = 2
) (
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        wrClk,
  input  logic [NUM_CH-1:0]        refMode,
  input  logic [NUM_CH*WORD_W-1:0] dataIn,
  output logic [NUM_CH*WORD_W-1:0] dataOut,
  output logic [NUM_CH-1:0]        outValid,
  output logic [NUM_CH-1:0]        driftErr
);

  logic [1:0] rdRstPipe;
  logic       rdRst;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdRstPipe <= '0;
    else       rdRstPipe <= {rdRstPipe[0], 1'b1};
  end

  assign rdRst = !rdRstPipe[1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    fifoStrobes_t chStrb;

    tx_elastic_ctrl #(
      .START_GAP(START_GAP)
    ) u_ctrl (
      .wrClk   (wrClk[ch]),
      .rdClk   (rdClk),
      .rstN    (rstN),
      .rdRst   (rdRst),
      .refMode (refMode[ch]),
      .strb    (chStrb),
      .driftErr(driftErr[ch])
    );

    tx_elastic_datapath #(
      .WORD_W(WORD_W)
    ) u_dp (
      .wrClk   (wrClk[ch]),
      .rdClk   (rdClk),
      .rdRst   (rdRst),
      .refMode (refMode[ch]),
      .dataIn  (dataIn[ch*WORD_W +: WORD_W]),
      .strb    (chStrb),
      .dataOut (dataOut[ch*WORD_W +: WORD_W]),
      .outValid(outValid[ch])
    );
  end

endmodule

// File: tb/tx_word_elastic_tb.sv
module tx_word_elastic_tb;

  logic        rdClk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdGate = 1'b1;
  logic        wrClkA = 1'b0;
  logic        wrClkB = 1'b0;
  logic [1:0]  wrGate = 2'b11;
  int          slip [2] = '{0, 0};
  logic [1:0]  refMode = 2'b00;
  logic [9:0]  dinW [2] = '{10'h001, 10'h200};
  logic [9:0]  dinR [2] = '{10'h055, 10'h0AA};
  logic [19:0] dataIn;
  logic [19:0] dataOut;
  logic [1:0]  outValid;
  logic [1:0]  driftErr;

  int checks = 0;
  int errors = 0;
  logic [9:0] wq [2][$];
  int  wrCnt [2] = '{0, 0};
  int  rdEdges = 0;
  bit  seen [2];
  bit  fault [2];
  bit  skipData [2];
  bit  errWatch [2];
  bit  done = 0;

  assign dataIn = {(refMode[1] ? dinR[1] : dinW[1]), (refMode[0] ? dinR[0] : dinW[0])};

  tx_word_elastic u_dut (
    .rdClk(rdClk), .rstN(rstN), .wrClk({wrClkB, wrClkA}), .refMode(refMode),
    .dataIn(dataIn), .dataOut(dataOut), .outValid(outValid), .driftErr(driftErr)
  );

  // 50 MHz read clock with a stop gate
  initial forever begin
    #10;
    rdClk = rdGate ? ~rdClk : 1'b0;
  end

  initial begin
    #3;
    forever begin
      if (slip[0] != 0) begin #(slip[0]); slip[0] = 0; end
      wrClkA = wrGate[0]; #10; wrClkA = 1'b0; #10;
    end
  end

  initial begin
    #14;
    forever begin
      if (slip[1] != 0) begin #(slip[1]); slip[1] = 0; end
      wrClkB = wrGate[1]; #10; wrClkB = 1'b0; #10;
    end
  end

  always @(negedge wrClkA) dinW[0] <= dinW[0] + 10'h13B;
  always @(negedge wrClkB) dinW[1] <= dinW[1] + 10'h0C7;
  always @(negedge rdClk) begin
    dinR[0] <= dinR[0] * 10'd5 + 10'd3;
    dinR[1] <= dinR[1] + 10'h111;
  end

  // Reference model: words accepted from the third write edge after reset (R1)
  always @(posedge wrClkA or negedge rstN) begin
    if (!rstN) begin wrCnt[0] = 0; wq[0].delete(); end
    else begin
      wrCnt[0] = wrCnt[0] + 1;
      if (!refMode[0] && wrCnt[0] >= 3) wq[0].push_back(dinW[0]);
    end
  end

  always @(posedge wrClkB or negedge rstN) begin
    if (!rstN) begin wrCnt[1] = 0; wq[1].delete(); end
    else begin
      wrCnt[1] = wrCnt[1] + 1;
      if (!refMode[1] && wrCnt[1] >= 3) wq[1].push_back(dinW[1]);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, sampled 5 ns after each read edge
  always @(posedge rdClk) begin
    logic [9:0] refSample [2];
    if (rstN) rdEdges = rdEdges + 1;
    refSample[0] = dataIn[9:0];
    refSample[1] = dataIn[19:10];
    #5;
    if (rstN && !done) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [9:0] dOut;
        dOut = dataOut[ch*10 +: 10];
        if (refMode[ch]) begin
          if (rdEdges >= 3) begin
            check(dOut == refSample[ch], "R6 ref data", dOut, refSample[ch]);
            check(outValid[ch] == 1'b1, "R6 ref valid", outValid[ch], 1);
          end else begin
            check(dOut == 10'd0 && !outValid[ch], "R4 ref early zero", dOut, 0);
          end
        end else if (outValid[ch]) begin
          if (!seen[ch]) check(rdEdges <= 12, "R2 start latency", rdEdges, 12);
          seen[ch] = 1'b1;
          if (!skipData[ch]) begin
            if (wq[ch].size() == 0) check(1'b0, "R1 word without write", dOut, 0);
            else begin
              logic [9:0] expW;
              expW = wq[ch].pop_front();
              check(dOut == expW, "R1 word order", dOut, expW);
            end
          end
        end else begin
          if (!seen[ch]) begin
            check(dOut == 10'd0, "R4 zero before first word", dOut, 0);
            if (rdEdges == 12) check(1'b0, "R2 no word by edge 12", rdEdges, 12);
          end else if (!fault[ch]) begin
            check(1'b0, "R3 valid gap", outValid[ch], 1);
          end
        end
        if (errWatch[ch]) check(driftErr[ch] == 1'b0, "R7 R6 flag stays low", driftErr[ch], 0);
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #37;
    check(dataOut == 20'd0, "R4 reset data", dataOut, 0);
    check(outValid == 2'b00, "R4 reset valid", outValid, 0);
    check(driftErr == 2'b00, "R5 reset clears flag", driftErr, 0);
    rdEdges = 0;
    for (int ch = 0; ch < 2; ch++) begin
      seen[ch] = 0; fault[ch] = 0; skipData[ch] = 0; errWatch[ch] = 1;
    end
    @(negedge rdClk); #4;
    rstN = 1'b1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // Pass 1: both channels through the FIFO
    doReset();
    repeat (60) @(posedge rdClk);
    check(seen[0] && seen[1], "R2 both started", {seen[1], seen[0]}, 3);

    // Underflow on channel 0: stop its write clock for four periods (R5, R7)
    fault[0] = 1; errWatch[0] = 0;
    @(negedge wrClkA); wrGate[0] = 1'b0;
    repeat (4) @(posedge rdClk);
    wrGate[0] = 1'b1;
    repeat (8) @(posedge rdClk);
    #5;
    check(driftErr[0] == 1'b1, "R5 underflow flag", driftErr[0], 1);
    check(driftErr[1] == 1'b0, "R7 other channel clean", driftErr[1], 0);
    repeat (20) @(posedge rdClk);
    #5;
    check(driftErr[0] == 1'b1, "R5 flag sticky", driftErr[0], 1);

    // Overflow on both: stop the read clock for six periods (R5)
    for (int ch = 0; ch < 2; ch++) begin
      fault[ch] = 1; skipData[ch] = 1; errWatch[ch] = 0;
    end
    @(negedge rdClk); #1; rdGate = 1'b0;
    #120;
    rdGate = 1'b1;
    repeat (8) @(posedge rdClk);
    #5;
    check(driftErr[1] == 1'b1, "R5 overflow flag", driftErr[1], 1);
    check(driftErr[0] == 1'b1, "R5 overflow flag ch0", driftErr[0], 1);

    // Pass 2: channel 0 bypassed with its write clock stopped, channel 1 phase shifted
    rstN = 1'b0;
    refMode = 2'b01;
    wrGate[0] = 1'b0;
    slip[1] = 7;
    #100;
    doReset();
    repeat (70) @(posedge rdClk);
    #5;
    check(driftErr == 2'b00, "R6 no flag in bypass", driftErr, 0);
    check(seen[1], "R2 shifted phase start", seen[1], 1);
    @(negedge rdClk);
    finishRun();
  end

endmodule